// File: doc/BRIEF.md
# SPI flash command engine

This block is a memory-mapped SPI master that runs a single serial flash transaction each time software starts it. Software first loads a command word that holds a command byte and a 24-bit flash address, and optionally a data word. It then writes the control word with a transmit byte count, a receive byte count, a clock-rate select and the start bit. The engine lowers chip select and shifts the transmit bytes out in SPI mode 0. It then clocks in the requested number of reply bytes, packs them into the data word, releases chip select and finally drops its busy flag.

One 4-bit transmit count covers the whole outgoing stream. The command byte comes first, then the three address bytes, then the data word bytes starting with the least significant one. A program command that carries N data bytes therefore uses a transmit count of N+4. A command byte alone is a count of 1, and command plus address is a count of 4. Software polls the busy flag to learn when the transaction has finished.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, the words at offsets 0x0, 0x4 and 0x8 read as zero, chip select `spi_cs_n` is high, and `spi_sck` and `spi_mosi` are low.
- R2: The control word is at offset 0x0, with the transmit count in bits [3:0], the receive count in bits [7:4] and the clock select in bits [25:24]. The command word is at 0x4 and holds the command byte in [7:0] and the address in [31:8]. The data word is at 0x8. Bit 8 of the control word and every unlisted bit read as 0, and any other offset reads as zero and ignores writes. A read returns its value one clock after the read strobe.
- R3: Writing 1 to control bit 8 with a nonzero byte count starts a transaction. Control bit 16 then reads 1 and chip select stays low until the transaction is over.
- R4: Transmit byte k is sent in this order: for k=0, command bits [7:0]; for k=1, 2 and 3, bits [31:24], [23:16] and [15:8]; for k=4..7, data bits [7:0], [15:8], [23:16] and [31:24]; for k≥8, 0x00. Each byte is sent most significant bit first.
- R5: Receive bytes follow the transmit bytes and are sampled most significant bit first. Reply byte r goes into data bits [8r+7:8r] for r<4, and reply bytes beyond the fourth are discarded. After a receive, the data bits that were not filled read 0. `spi_mosi` is 0 while receiving, and a receive count of 0 leaves the data word unchanged.
- R6: SPI mode 0 framing. SCK idles low and pulses only while chip select is low. `spi_mosi` is stable while SCK is high, MISO is sampled on the rising edge, and exactly 8×(tx+rx) rising edges are produced.
- R7: For clock select s (0..3), each high and low phase of SCK lasts 2^s system clocks, so SCK runs at the system clock divided by 2, 4, 8 or 16.
- R8: Chip select returns high at least one full SCK period before the busy bit reads 0.
- R9: While busy, writes to any word are ignored, including a new start request. The command, data and control words and the running transaction are left untouched.
- R10: A start request with both counts zero does nothing. Busy stays 0 and chip select never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps every transmit count from 0 to 9 against every receive count from 0 to 5, and adds long transfers at every clock select. The sweep catches a design that sends the address least significant byte first, that reads the wrong data lane, or that runs past the fourth data byte without sending zero padding. Receive counts above four and a receive count of zero expose a design that wraps reply bytes, leaves stale bits in the data word, or clobbers it when nothing was requested. Starting from a timed chip-select release, writes issued during a transaction, and a start with zero counts, the bench catches three more faults: a busy flag that falls with chip select, a second start that gets in, and a spurious empty frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = WORD_W / BYTE_W;
  localparam int unsigned SEL_W  = 2;

  // word indices (byte offset / 4)
  localparam logic [1:0] IDX_CTL = 2'd0;
  localparam logic [1:0] IDX_CMD = 2'd1;
  localparam logic [1:0] IDX_DAT = 2'd2;

  // control word field positions
  localparam int unsigned CTL_TX_LSB   = 0;
  localparam int unsigned CTL_RX_LSB   = 4;
  localparam int unsigned CTL_GO_BIT   = 8;
  localparam int unsigned CTL_BUSY_BIT = 16;
  localparam int unsigned CTL_SEL_LSB  = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_GAP1,
    ST_GAP2
  } seq_state_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              go_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic [CNT_W-1:0]  rx_cnt_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] dat_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [CNT_W-1:0]  tx_q, rx_q, tx_new, rx_new;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] cmd_q, dat_q, dat_d, rdata_q, rdata_d, ctl_word;
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  word_idx;
  logic              aligned, sel_ctl, sel_cmd, sel_dat, wr_ok;
  logic              ctl_en, cmd_en, dat_en, rd_en;

  // decode
  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    aligned  = (bus_addr[1:0] == 2'b00);
    sel_ctl  = aligned && (word_idx == IDX_W'(IDX_CTL));
    sel_cmd  = aligned && (word_idx == IDX_W'(IDX_CMD));
    sel_dat  = aligned && (word_idx == IDX_W'(IDX_DAT));
    wr_ok    = bus_wr && !busy_q;
    tx_new   = bus_wdata[CTL_TX_LSB +: CNT_W];
    rx_new   = bus_wdata[CTL_RX_LSB +: CNT_W];
    go_o     = wr_ok && sel_ctl && bus_wdata[CTL_GO_BIT] &&
               ((tx_new != '0) || (rx_new != '0));
    ctl_en   = wr_ok && sel_ctl;
    cmd_en   = wr_ok && sel_cmd;
    dat_en   = (wr_ok && sel_dat) || (done_i && (rx_q != '0));
    rd_en    = bus_rd;
  end

  // next state
  always_comb begin
    busy_d = busy_q;
    if (go_o)        busy_d = 1'b1;
    else if (done_i) busy_d = 1'b0;

    dat_d = (done_i && (rx_q != '0)) ? rx_word_i : bus_wdata;

    ctl_word = '0;
    ctl_word[CTL_TX_LSB +: CNT_W]  = tx_q;
    ctl_word[CTL_RX_LSB +: CNT_W]  = rx_q;
    ctl_word[CTL_BUSY_BIT]         = busy_q;
    ctl_word[CTL_SEL_LSB +: SEL_W] = sel_q;

    rdata_d = '0;
    if (sel_ctl)      rdata_d = ctl_word;
    else if (sel_cmd) rdata_d = cmd_q;
    else if (sel_dat) rdata_d = dat_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      sel_q   <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      busy_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (ctl_en) begin
        tx_q  <= tx_new;
        rx_q  <= rx_new;
        sel_q <= bus_wdata[CTL_SEL_LSB +: SEL_W];
      end
      if (cmd_en) cmd_q   <= bus_wdata;
      if (dat_en) dat_q   <= dat_d;
      if (rd_en)  rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign busy_o    = busy_q;
  assign tx_cnt_o  = tx_q;
  assign rx_cnt_o  = rx_q;
  assign sel_o     = sel_q;
  assign cmd_o     = cmd_q;
  assign dat_o     = dat_q;

  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && sel_cmd) |=> $stable(cmd_q)); // R9

  AST_CTL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && sel_ctl) |=> ($stable(tx_q) && $stable(rx_q) && $stable(sel_q))); // R9
endmodule

// File: rtl/spi_cmd_clkgen.sv
module spi_cmd_clkgen
  import spi_cmd_pkg::*;
#(
  parameter int unsigned S_W = SEL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [S_W-1:0] sel_i,
  output logic           tick_o
);
  localparam int unsigned DIV_CNT_W = (1 << S_W) - 1;

  logic [DIV_CNT_W-1:0] cnt_q, cnt_d, lim;
  logic                 cnt_en;

  always_comb begin
    lim    = DIV_CNT_W'((32'd1 << sel_i) - 32'd1);
    tick_o = en_i && (cnt_q == lim);
    cnt_en = en_i || (cnt_q != '0);
    cnt_d  = (!en_i || tick_o) ? '0 : cnt_q + DIV_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o
);
  localparam int unsigned BYTE_IDX_W = CNT_W + 1;
  localparam int unsigned BIT_W      = BYTE_IDX_W + 3;
  localparam int unsigned LANE_W     = $clog2(LANES);

  seq_state_t             state_q, state_d;
  logic [BIT_W-1:0]       bit_q, bit_d, last_bit;
  logic                   sck_q, sck_d, cs_n_q, cs_n_d;
  logic [WORD_W-1:0]      rxw_q, rxw_d;
  logic [BYTE_IDX_W-1:0]  total_bytes, last_byte, byte_idx, rx_idx;
  logic [2:0]             bpos;
  logic                   in_tx, rx_keep, framed;
  logic [BYTE_W-1:0]      tx_byte;
  logic [LANE_W+2:0]      rx_pos;

  // stream position decode
  always_comb begin
    total_bytes = BYTE_IDX_W'(tx_cnt_i) + BYTE_IDX_W'(rx_cnt_i);
    last_byte   = total_bytes - BYTE_IDX_W'(1);
    last_bit    = {last_byte, 3'b111};
    byte_idx    = bit_q[BIT_W-1:3];
    bpos        = bit_q[2:0];
    in_tx       = byte_idx < BYTE_IDX_W'(tx_cnt_i);
    rx_idx      = byte_idx - BYTE_IDX_W'(tx_cnt_i);
    rx_keep     = !in_tx && (rx_idx < BYTE_IDX_W'(LANES));
    rx_pos      = {rx_idx[LANE_W-1:0], ~bpos};

    // command byte, address high to low, then data low to high, then padding
    if (byte_idx == '0)
      tx_byte = cmd_i[BYTE_W-1:0];
    else if (byte_idx < BYTE_IDX_W'(LANES))
      tx_byte = cmd_i[(LANES - int'(byte_idx)) * BYTE_W +: BYTE_W];
    else if (byte_idx < BYTE_IDX_W'(2 * LANES))
      tx_byte = dat_i[(int'(byte_idx) - LANES) * BYTE_W +: BYTE_W];
    else
      tx_byte = '0;

    framed = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TRAIL);
    mosi_o = framed && in_tx && tx_byte[~bpos];
  end

  // next state
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    rxw_d   = rxw_q;
    unique case (state_q)
      ST_IDLE: if (go_i) begin
        state_d = ST_LOW;
        bit_d   = '0;
        cs_n_d  = 1'b0;
        rxw_d   = '0;
      end
      ST_LOW: if (tick_i) begin
        sck_d   = 1'b1;
        state_d = ST_HIGH;
        if (rx_keep) rxw_d[rx_pos] = miso_i;
      end
      ST_HIGH: if (tick_i) begin
        sck_d = 1'b0;
        if (bit_q == last_bit) begin
          state_d = ST_TRAIL;
        end else begin
          bit_d   = bit_q + BIT_W'(1);
          state_d = ST_LOW;
        end
      end
      ST_TRAIL: if (tick_i) begin
        cs_n_d  = 1'b1;
        state_d = ST_GAP1;
      end
      ST_GAP1: if (tick_i) state_d = ST_GAP2;
      ST_GAP2: if (tick_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      rxw_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      rxw_q   <= rxw_d;
    end
  end

  assign active_o  = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_GAP2) && tick_i;
  assign rx_word_o = rxw_q;
  assign sck_o     = sck_q;
  assign cs_n_o    = cs_n_q;

  AST_SCK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(sck_q)); // R7

  AST_GAP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_q && $past(cs_n_q) && !sck_q)); // R8
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              rst_meta, rst_sync;
  logic              go, busy, done, active, tick;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] cmd, dat, rx_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  spi_cmd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done_i    (done),
    .rx_word_i (rx_word),
    .go_o      (go),
    .busy_o    (busy),
    .tx_cnt_o  (tx_cnt),
    .rx_cnt_o  (rx_cnt),
    .sel_o     (sel),
    .cmd_o     (cmd),
    .dat_o     (dat)
  );

  spi_cmd_clkgen #(.S_W(SEL_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_sync),
    .en_i   (active),
    .sel_i  (sel),
    .tick_o (tick)
  );

  spi_cmd_shifter #(.CNT_W(CNT_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_sync),
    .go_i      (go),
    .tick_i    (tick),
    .tx_cnt_i  (tx_cnt),
    .rx_cnt_i  (rx_cnt),
    .cmd_i     (cmd),
    .dat_i     (dat),
    .miso_i    (spi_miso),
    .active_o  (active),
    .done_o    (done),
    .rx_word_o (rx_word),
    .sck_o     (spi_sck),
    .cs_n_o    (spi_cs_n),
    .mosi_o    (spi_mosi)
  );

  AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync)
    !busy |-> spi_cs_n); // R3

  AST_SCK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_sync)
    spi_sck |-> !spi_cs_n); // R6

  AST_ACTIVE_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_sync)
    go |=> (busy && active)); // R3
endmodule

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  localparam time TCK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;

  always #(TCK/2) clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash-side model ----------------
  logic [7:0]  seed = 8'h00;
  int          rise_cnt = 0;
  int          cs_falls = 0;
  logic [7:0]  mosi_bytes [0:31];
  logic        mosi_at_rise = 1'b0;
  time         last_rise = 0, t_csr = 0, exp_half = 10, exp_period = 20;
  int          period_err = 0, high_err = 0, mosi_err = 0;

  function automatic logic [7:0] resp_byte(input logic [7:0] s, input int i);
    logic [7:0] v;
    v = 8'(i) * 8'h3B;
    return (v + s) ^ 8'hA5;
  endfunction

  function automatic logic resp_bit(input logic [7:0] s, input int n);
    logic [7:0] b;
    b = resp_byte(s, n / 8);
    return b[7 - (n % 8)];
  endfunction

  assign spi_miso = resp_bit(seed, rise_cnt);

  always @(negedge spi_cs_n) begin
    cs_falls = cs_falls + 1;
    rise_cnt = 0;
    for (int i = 0; i < 32; i++) mosi_bytes[i] = 8'h00;
  end

  always @(posedge spi_cs_n) t_csr = $time;

  always @(posedge spi_sck) begin
    if (rise_cnt < 256) mosi_bytes[rise_cnt / 8][7 - (rise_cnt % 8)] = spi_mosi;
    mosi_at_rise = spi_mosi;
    if (rise_cnt > 0 && ($time - last_rise) != exp_period) period_err = period_err + 1;
    last_rise = $time;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge spi_sck) begin
    if (($time - last_rise) != exp_half) high_err = high_err + 1;
  end

  always @(negedge clk) begin
    if (spi_sck && (spi_mosi !== mosi_at_rise)) mosi_err = mosi_err + 1;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output time elapsed);
    logic [31:0] v;
    int n;
    n = 0;
    do begin
      rd(4'h0, v);
      n = n + 1;
    end while (v[16] && n < 20000);
    elapsed = $time - t_csr;
  endtask

  function automatic logic [7:0] exp_tx(input logic [31:0] op, input logic [31:0] dt, input int j);
    if (j == 0) return op[7:0];
    if (j < 4)  return op[(4 - j) * 8 +: 8];
    if (j < 8)  return dt[(j - 4) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic run(input logic [31:0] op, input logic [31:0] dt,
                     input int tx, input int rx, input int sel);
    logic [31:0] v, exp_dat;
    time el;
    exp_half = TCK * (1 << sel);
    exp_period = 2 * exp_half;
    seed = op[7:0] ^ 8'(tx * 16 + rx);
    period_err = 0; high_err = 0; mosi_err = 0;
    wr(4'h8, dt);
    wr(4'h4, op);
    wr(4'h0, (32'(sel) << 24) | (32'(rx) << 4) | 32'(tx) | 32'h100);
    rd(4'h0, v);
    chk("R3 busy bit during transfer", {31'b0, v[16]}, 32'd1);
    chk("R3 chip select low during transfer", {31'b0, spi_cs_n}, 32'd0);
    wait_idle(el);
    chk("R8 cs high one SCK period before idle", {31'b0, el >= exp_period}, 32'd1);
    chk("R6 rising edge count", 32'(rise_cnt), 32'(8 * (tx + rx)));
    chk("R6 mosi stable while SCK high", 32'(mosi_err), 32'd0);
    chk("R7 SCK period", 32'(period_err), 32'd0);
    chk("R7 SCK high phase", 32'(high_err), 32'd0);
    for (int j = 0; j < tx; j++)
      chk($sformatf("R4 tx byte %0d", j), {24'b0, mosi_bytes[j]}, {24'b0, exp_tx(op, dt, j)});
    for (int r = 0; r < rx; r++)
      chk($sformatf("R5 mosi zero in rx byte %0d", r), {24'b0, mosi_bytes[tx + r]}, 32'd0);
    exp_dat = dt;
    if (rx > 0) begin
      exp_dat = '0;
      for (int r = 0; r < rx && r < 4; r++) exp_dat[r * 8 +: 8] = resp_byte(seed, tx + r);
    end
    rd(4'h8, v);
    chk($sformatf("R5 data word tx=%0d rx=%0d", tx, rx), v, exp_dat);
    rd(4'h0, v);
    chk("R2 control readback after transfer", v, (32'(sel) << 24) | (32'(rx) << 4) | 32'(tx));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(TCK * 200000);
    miscompares = miscompares + 1;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int f0;
    time el;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'h0, v); chk("R1 control after reset", v, 32'd0);
    rd(4'h4, v); chk("R1 command after reset", v, 32'd0);
    rd(4'h8, v); chk("R1 data after reset", v, 32'd0);
    chk("R1 pins after reset", {29'b0, spi_cs_n, spi_sck, spi_mosi}, 32'b100);

    // R2 register map
    wr(4'h0, 32'hFEFE_FE5A);
    rd(4'h0, v); chk("R2 control fields", v, 32'h0200_005A);
    wr(4'h4, 32'h1234_5678);
    rd(4'h4, v); chk("R2 command word", v, 32'h1234_5678);
    wr(4'h8, 32'h9ABC_DEF0);
    rd(4'h8, v); chk("R2 data word", v, 32'h9ABC_DEF0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); chk("R2 unmapped offset", v, 32'd0);
    chk("R2 no frame from plain writes", 32'(cs_falls), 32'd0);

    // R10 start with zero counts
    f0 = cs_falls;
    wr(4'h0, 32'h0200_0100);
    rd(4'h0, v); chk("R10 zero-count start keeps busy low", v, 32'h0200_0000);
    repeat (20) @(negedge clk);
    chk("R10 no chip select activity", 32'(cs_falls - f0), 32'd0);
    chk("R10 chip select high", {31'b0, spi_cs_n}, 32'd1);

    // sweep of counts at the fastest clock
    for (int t = 0; t <= 9; t++)
      for (int r = 0; r <= 5; r++)
        if (t + r > 0)
          run(32'hC3A5_5A00 ^ 32'(t * 7 + r), 32'h0F1E_2D3C ^ 32'(r << 8), t, r, 0);

    // every clock select, long frames and padding
    for (int s = 0; s < 4; s++) begin
      run(32'h0102_03D8, 32'hAABB_CCDD, 1, 1, s);
      run(32'h8040_2002, 32'h1122_3344, 8, 0, s);
      run(32'hFFEE_DD0B, 32'h5566_7788, 5, 4, s);
    end
    run(32'h7654_3210, 32'hDEAD_BEEF, 15, 15, 3);
    run(32'h0000_00AB, 32'h0000_0000, 12, 6, 1);

    // R9 writes while busy are ignored
    f0 = cs_falls;
    exp_half = TCK * 2; exp_period = TCK * 4;
    seed = 8'h11;
    wr(4'h8, 32'hCAFE_F00D);
    wr(4'h4, 32'h0BAD_1E02);
    wr(4'h0, 32'h0100_0106);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0000_0000);
    wr(4'h0, 32'h0000_0132);
    wait_idle(el);
    rd(4'h4, v); chk("R9 command unchanged by busy write", v, 32'h0BAD_1E02);
    rd(4'h8, v); chk("R9 data unchanged by busy write", v, 32'hCAFE_F00D);
    rd(4'h0, v); chk("R9 control unchanged by busy write", v, 32'h0100_0006);
    chk("R9 single frame", 32'(cs_falls - f0), 32'd1);
    chk("R9 original length kept", 32'(rise_cnt), 32'd48);
    chk("R9 data byte 1 as loaded", {24'b0, mosi_bytes[5]}, 32'h0000_00F0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule